// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block runs the receive side of a network controller that moves frames into system memory itself. Software builds a ring of two-word descriptors in memory, each pointing at a fixed 128-byte buffer, and sets the ring's start address while receive is switched off. Once receive is switched on, the walker reads each descriptor in turn. When the controller owns an entry, the walker offers that buffer's address to the frame-writing logic and waits for it to report the buffer full. It then stores a status word and hands the entry back to software. A frame longer than one buffer simply uses several descriptors in a row.

The ring closes in two ways. A descriptor may carry a wrap mark, after which the walk goes back to the ring start. Without a mark, the walk returns to the start after a fixed number of entries (1024 by default). If the walker meets an entry that software still holds, it stops. It raises a no-buffer flag and stays put until receive is switched off and on again. The address of the descriptor in use can be read at any time.

Top module: `rx_desc_walker`

## Requirements
- R1: After reset, `cur_desc` is 0 and `no_buf`, `mem_req` and `buf_valid` are all low.
- R2: A write on `cfg_base_we` loads the ring start address, with its three low bits forced to 0, only while `rx_enable` is low. A write while `rx_enable` is high has no effect, which shows at the next enable.
- R3: On the first cycle `rx_enable` is high after being low, `cur_desc` becomes the ring start. The walker then issues a read of descriptor word 0 at `cur_desc`.
- R4: When word 0 has bit 0 (the ownership bit) at 0, `buf_valid` rises with `buf_addr` equal to word 0 with bits 1:0 cleared. Both stay steady until `buf_done`.
- R5: After `buf_done`, the walker first writes `buf_status` to address `cur_desc`+4. It then writes word 0 back to `cur_desc` with bit 0 set to 1, and all its other bits unchanged.
- R6: After that write-back, the next descriptor is at `cur_desc`+8.
- R7: If word 0 had bit 1 (the wrap bit) set, the next descriptor is at the ring start.
- R8: After RING_MAX descriptors with no wrap bit seen, the next descriptor is at the ring start.
- R9: A fetched word 0 with bit 0 at 1 raises `no_buf`. While `rx_enable` stays high, `no_buf` stays high, `cur_desc` holds, and no memory request or buffer offer is made, even if the descriptor is changed in memory.
- R10: One cycle after `rx_enable` is seen low, `mem_req`, `buf_valid` and `no_buf` are low.
- R11: Every memory request addresses a word of the descriptor at `cur_desc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_we | input | 1 | Load ring start address |
| cfg_base_wdata | input | AW | Ring start address |
| rx_enable | input | 1 | Receive switched on |
| cur_desc | output | AW | Address of the descriptor in use |
| no_buf | output | 1 | Walker stopped on a software-held entry |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | DW | Read data |
| buf_valid | output | 1 | Buffer address offered |
| buf_addr | output | DW | Buffer start address |
| buf_done | input | 1 | Offered buffer has been filled |
| buf_status | input | DW | Status word to store for that buffer |

## Verification
The bound checker watches, on every cycle, the parts of the block that hold from one cycle to the next. These are: a buffer offer held steady until completion, the stall holding its place, the quiet outputs after disable, start-address changes only while disabled, requests confined to the current descriptor, and pointer moves that are either +8 or back to the start. Only the bench's scenarios can show the rest. That covers the exact buffer address masked out of word 0, the status and ownership words that land in memory, and the return to the start from a wrap bit or from the entry count. It also covers a start-address write made while enabled, which shows its lack of effect only at the next enable.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_OFFER,
    S_WR_STAT,
    S_WR_OWN,
    S_STALL
  } walk_state_e;

  localparam int OWN_BIT    = 0;
  localparam int WRAP_BIT   = 1;
  localparam int DESC_BYTES = 8;
  localparam int STAT_OFS   = 4;
endpackage

// File: rtl/rxw_cfg.sv
module rxw_cfg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          rx_enable,
  output logic [AW-1:0] base_q,
  output logic          start
);
  logic          en_q;
  logic [AW-1:0] base_d;
  logic          base_ld;

  always_comb begin
    base_ld = base_we && !rx_enable;
    base_d  = {base_wdata[AW-1:3], 3'b000};
    start   = rx_enable && !en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= rx_enable;
      if (base_ld) base_q <= base_d;
    end
  end
endmodule

// File: rtl/rxw_ring_ptr.sv
module rxw_ring_ptr #(
  parameter int AW       = 32,
  parameter int RING_MAX = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          wrap_seen,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] cur
);
  import rxw_pkg::*;
  localparam int IDX_W = (RING_MAX > 1) ? $clog2(RING_MAX) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RING_MAX - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [AW-1:0]    cur_d;
  logic             upd;

  always_comb begin
    upd   = load || step;
    cur_d = cur;
    idx_d = idx_q;
    if (load) begin
      cur_d = base;
      idx_d = '0;
    end else if (step) begin
      if (wrap_seen || idx_q == IDX_LAST) begin
        cur_d = base;
        idx_d = '0;
      end else begin
        cur_d = cur + AW'(DESC_BYTES);
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '0;
      idx_q <= '0;
    end else if (upd) begin
      cur   <= cur_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          start,
  input  logic [AW-1:0] cur,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          buf_valid,
  output logic [DW-1:0] buf_addr,
  input  logic          buf_done,
  input  logic [DW-1:0] buf_status,
  output logic          no_buf,
  output logic          step,
  output logic          wrap_seen
);
  import rxw_pkg::*;

  walk_state_e   state_q, state_d;
  logic [DW-1:0] word0_q, stat_q;
  logic          word0_ld, stat_ld;

  always_comb begin
    state_d  = state_q;
    word0_ld = 1'b0;
    stat_ld  = 1'b0;
    step     = 1'b0;
    case (state_q)
      S_IDLE:    if (start) state_d = S_FETCH;
      S_FETCH:   if (mem_ack) begin
                   word0_ld = 1'b1;
                   state_d  = mem_rdata[OWN_BIT] ? S_STALL : S_OFFER;
                 end
      S_OFFER:   if (buf_done) begin
                   stat_ld = 1'b1;
                   state_d = S_WR_STAT;
                 end
      S_WR_STAT: if (mem_ack) state_d = S_WR_OWN;
      S_WR_OWN:  if (mem_ack) begin
                   step    = 1'b1;
                   state_d = S_FETCH;
                 end
      S_STALL:   state_d = S_STALL;
      default:   state_d = S_IDLE;
    endcase
    if (!rx_enable) begin
      state_d  = S_IDLE;
      step     = 1'b0;
      word0_ld = 1'b0;
      stat_ld  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      word0_q <= '0;
      stat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (word0_ld) word0_q <= mem_rdata;
      if (stat_ld)  stat_q  <= buf_status;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = word0_q;
    mem_wdata[OWN_BIT] = 1'b1;
    case (state_q)
      S_FETCH:   mem_req = 1'b1;
      S_WR_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur + AW'(STAT_OFS);
        mem_wdata = stat_q;
      end
      S_WR_OWN:  begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default:   mem_req = 1'b0;
    endcase
    buf_valid = (state_q == S_OFFER);
    buf_addr  = {word0_q[DW-1:2], 2'b00};
    no_buf    = (state_q == S_STALL);
    wrap_seen = word0_q[WRAP_BIT];
  end
endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int RING_MAX = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_base_we,
  input  logic [AW-1:0] cfg_base_wdata,
  input  logic          rx_enable,
  output logic [AW-1:0] cur_desc,
  output logic          no_buf,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          buf_valid,
  output logic [DW-1:0] buf_addr,
  input  logic          buf_done,
  input  logic [DW-1:0] buf_status
);
  logic [AW-1:0] base_q;
  logic          start, step, wrap_seen;

  rxw_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .base_we(cfg_base_we), .base_wdata(cfg_base_wdata),
    .rx_enable(rx_enable), .base_q(base_q), .start(start)
  );

  rxw_ring_ptr #(.AW(AW), .RING_MAX(RING_MAX)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step), .wrap_seen(wrap_seen),
    .base(base_q), .cur(cur_desc)
  );

  rxw_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .start(start), .cur(cur_desc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_done(buf_done), .buf_status(buf_status), .no_buf(no_buf), .step(step),
    .wrap_seen(wrap_seen)
  );
endmodule

module rx_desc_walker_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_enable,
  input logic          no_buf,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          buf_valid,
  input logic [DW-1:0] buf_addr,
  input logic          buf_done,
  input logic [AW-1:0] cur_desc,
  input logic [AW-1:0] base_q
);
  assert_base_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q != $past(base_q)) |-> !$past(rx_enable));

  assert_offer_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_done && rx_enable) |=> (buf_valid && $stable(buf_addr)));

  assert_addr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (buf_addr[1:0] == 2'b00));

  assert_ptr_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && $past(rx_enable) && (cur_desc != $past(cur_desc)))
      |-> ((cur_desc == $past(cur_desc) + AW'(8)) || (cur_desc == base_q)));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (no_buf && rx_enable) |=> (no_buf && $stable(cur_desc) && !mem_req && !buf_valid));

  assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (!mem_req && !buf_valid && !no_buf));

  assert_req_in_desc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[AW-1:3] == cur_desc[AW-1:3]));
endmodule

bind rx_desc_walker rx_desc_walker_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .no_buf(no_buf),
  .mem_req(mem_req), .mem_addr(mem_addr), .buf_valid(buf_valid),
  .buf_addr(buf_addr), .buf_done(buf_done), .cur_desc(cur_desc), .base_q(base_q)
);

// File: tb/rx_desc_walker_tb.sv
module rx_desc_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int RMAX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_base_we = 1'b0;
  logic [AW-1:0] cfg_base_wdata = '0;
  logic rx_enable = 1'b0;
  logic [AW-1:0] cur_desc;
  logic no_buf, mem_req, mem_we, buf_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, buf_addr;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic buf_done = 1'b0;
  logic [DW-1:0] buf_status = '0;

  logic [31:0] mem [0:127];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_walker #(.AW(AW), .DW(DW), .RING_MAX(RMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
    .rx_enable(rx_enable), .cur_desc(cur_desc), .no_buf(no_buf), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_done(buf_done), .buf_status(buf_status)
  );

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[8:2]];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000 && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<50000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_desc(input int a, input logic [31:0] w0, input logic [31:0] w1);
    mem[a >> 2]       = w0;
    mem[(a >> 2) + 1] = w1;
  endtask

  task automatic wait_evt();
    for (int k = 0; k < 40; k++) begin
      if (buf_valid || no_buf) break;
      @(negedge clk);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    cfg_base_we = 1'b1; cfg_base_wdata = b;
    @(negedge clk);
    cfg_base_we = 1'b0;
  endtask

  task automatic set_en(input logic e);
    rx_enable = e;
    @(negedge clk);
  endtask

  task automatic serve(input int da, input logic [31:0] w0, input logic [31:0] st);
    wait_evt();
    chk("R4 buf_valid", {31'd0, buf_valid}, 32'd1);
    chk("R4 buf_addr masked", buf_addr, w0 & ~32'd3);
    chk("R6 cur_desc", cur_desc, da);
    buf_done = 1'b1; buf_status = st;
    @(negedge clk);
    buf_done = 1'b0;
    wait_evt();
    chk("R5 status word", mem[(da >> 2) + 1], st);
    chk("R5 owner word", mem[da >> 2], w0 | 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0000_0001;
    repeat (3) @(negedge clk);
    chk("R1 cur_desc", cur_desc, 32'd0);
    chk("R1 no_buf", {31'd0, no_buf}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 buf_valid", {31'd0, buf_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep ring sizes closed by the wrap bit (R7)
    for (int n = 1; n <= 4; n++) begin
      for (int i = 0; i < n; i++)
        set_desc(i * 8, 32'h4000_0000 + ((16 * n + i) << 7) + ((i == n - 1) ? 2 : 0), 32'd0);
      set_base(32'h0000_0000);
      set_en(1'b1);
      chk("R3 cur_desc at start", cur_desc, 32'd0);
      for (int i = 0; i < n; i++)
        serve(i * 8, 32'h4000_0000 + ((16 * n + i) << 7) + ((i == n - 1) ? 2 : 0),
              32'hA000_0000 | (n << 8) | i);
      chk("R9 no_buf after wrap", {31'd0, no_buf}, 32'd1);
      chk("R7 wrapped to start", cur_desc, 32'd0);
      repeat (5) @(negedge clk);
      chk("R9 no request while stalled", {31'd0, mem_req}, 32'd0);
      chk("R9 no offer while stalled", {31'd0, buf_valid}, 32'd0);
      mem[0] = mem[0] & ~32'd1;
      repeat (4) @(negedge clk);
      chk("R9 stall holds after memory change", {31'd0, no_buf}, 32'd1);
      chk("R9 cur_desc holds", cur_desc, 32'd0);
      set_en(1'b0);
      chk("R10 no_buf cleared", {31'd0, no_buf}, 32'd0);
      chk("R10 mem_req low", {31'd0, mem_req}, 32'd0);
    end

    // Ring closed by the entry count (R8)
    for (int i = 0; i < RMAX; i++) set_desc(32'h100 + i * 8, 32'h5000_0000 + (i << 7), 32'd0);
    set_base(32'h0000_0100);
    set_en(1'b1);
    chk("R3 cur_desc at start", cur_desc, 32'h100);
    for (int i = 0; i < RMAX; i++) serve(32'h100 + i * 8, 32'h5000_0000 + (i << 7), 32'h5500_0000 + i);
    chk("R8 no_buf at start entry", {31'd0, no_buf}, 32'd1);
    chk("R8 back to start", cur_desc, 32'h100);
    set_en(1'b0);

    // Start-address write while enabled, and disable mid-offer (R2, R10)
    set_desc(32'h100, 32'h5800_0000, 32'd0);
    set_en(1'b1);
    wait_evt();
    chk("R4 offer before base write", {31'd0, buf_valid}, 32'd1);
    set_base(32'h0000_0043);
    rx_enable = 1'b0;
    @(negedge clk);
    chk("R10 offer dropped", {31'd0, buf_valid}, 32'd0);
    set_en(1'b1);
    wait_evt();
    chk("R2 write while enabled ignored", cur_desc, 32'h100);
    chk("R2 buffer from old start", buf_addr, 32'h5800_0000);
    set_en(1'b0);
    set_base(32'h0000_0043);
    set_desc(32'h40, 32'h6000_0002, 32'd0);
    set_en(1'b1);
    chk("R2 start loaded and aligned", cur_desc, 32'h40);
    serve(32'h40, 32'h6000_0002, 32'h7777_0001);
    chk("R7 single entry wraps", cur_desc, 32'h40);
    chk("R9 stall on returned entry", {31'd0, no_buf}, 32'd1);
    set_en(1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule